// File: doc/BRIEF.md
# Halfword DMA Engine Between Main Memory and Cartridge Space

This block copies data between a main-memory port and a cartridge-side port in 16-bit steps. Software sets it up through a small 32-bit register window. It writes a memory start address and a cartridge start address, then writes a length. The length register that is written selects the direction and starts the copy. Both data ports are request/acknowledge handshakes: the engine holds `valid` with a stable address until the far side raises `ready`. Read data is taken in the acknowledging cycle, and writes complete in that same cycle.

Each halfword costs one read on the source side and one write on the destination side. Both address registers then step by two, so after a transfer they read back the next free location. A status register reports progress, and its meaning depends on whether it is read or written. On read it gives the engine's state. On write it can abort the current copy or acknowledge a completion. A level interrupt follows the completion flag. Cartridge bus timing lies outside this block; a separate sequencer handles it behind the cartridge handshake.

Top module: `pdma_ctrl`

## Requirements
- R1: Register byte offsets are 0x00 memory address, 0x04 cartridge address, 0x08 memory-to-cartridge length, 0x0C cartridge-to-memory length and 0x10 status. The select is `reg_addr[4:2]`. Address bit 0 is stored and read back as 0, and no port request ever carries an odd address.
- R2: Writing offset 0x08 while idle starts a memory-to-cartridge copy. The value is kept with bit 0 forced to 1, so the copy moves (value|1)+1 bytes, always a whole number of halfwords. The kept value reads back at 0x08.
- R3: Writing offset 0x0C while idle starts a cartridge-to-memory copy of value+1 bytes, and the value reads back unchanged. Within a halfword, bits 7:0 hold the lower byte address. For an odd byte count, the final memory write carries `mem_be`=01. Every other memory write carries `mem_be`=11.
- R4: For each halfword the engine reads the source side and then writes the destination side, and never requests on both ports at once. Both addresses then advance by 2. After completion they read back as start plus twice the halfword count.
- R5: A status read returns bit 0 busy, bit 1 cartridge request outstanding, bit 2 error, bit 3 completion pending, and bit 4 set when memory address bits 2:0 are zero. All other bits read 0.
- R6: In the cycle where busy drops at the end of a copy, the completion bit becomes 1. The `irq` output always equals that bit.
- R7: A status write with bit 1 set clears the completion bit and `irq`.
- R8: A status write with bit 0 set aborts any copy at once. It clears busy, error and completion, and no further port requests follow. The address registers keep their values from the moment of the abort.
- R9: A length write while busy sets the error bit. It does not change the running copy or the stored length values.
- R10: While a port request waits for `ready`, `valid` stays high and the address stays stable.
- R11: Writes to either address register are ignored while busy.
- R12: After hardware reset every register reads 0 except status bit 4, which reads 1. No port request is active and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| mem_valid | output | 1 | Memory-side request |
| mem_ready | input | 1 | Memory-side acknowledge |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory byte address (even) |
| mem_wdata | output | 16 | Memory write halfword |
| mem_be | output | 2 | Memory byte enables |
| mem_rdata | input | 16 | Memory read halfword, valid while `mem_ready` is high |
| cart_valid | output | 1 | Cartridge-side request |
| cart_ready | input | 1 | Cartridge-side acknowledge |
| cart_we | output | 1 | Cartridge request is a write |
| cart_addr | output | AW | Cartridge byte address (even) |
| cart_wdata | output | 16 | Cartridge write halfword |
| cart_rdata | input | 16 | Cartridge read halfword, valid while `cart_ready` is high |
| irq | output | 1 | Completion interrupt level |

## Verification
Most wrong internal states show up in the destination array when a copy ends. A miscounted remainder writes one halfword too many or too few. A wrong buffer corrupts a byte, and a wrong final enable disturbs the neighbouring byte. The bench sees each of these within a few cycles of busy dropping, because it compares the entire model memory against arithmetic expectations. Bad sequencing of busy and completion is caught in the first status poll after the last write. Address registers that step wrongly are caught at readback, and a lost abort or ignore rule is caught within ten cycles through the port valids and the status word.

// File: rtl/pdma_ctrl.sv
module pdma_ctrl #(
  parameter int AW = 24,
  parameter int LW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [4:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  output logic [1:0]    mem_be,
  input  logic [15:0]   mem_rdata,
  output logic          cart_valid,
  input  logic          cart_ready,
  output logic          cart_we,
  output logic [AW-1:0] cart_addr,
  output logic [15:0]   cart_wdata,
  input  logic [15:0]   cart_rdata,
  output logic          irq
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_STORE} st_t;

  st_t           st;
  logic          to_cart, err, irq_q;
  logic [AW-1:0] maddr, caddr;
  logic [LW-1:0] len_m2c, len_c2m, cnt;
  logic [15:0]   hbuf;
  logic [2:0]    idx;
  logic          busy, sr_wr, clr_wr, len_wr, src_fire, dst_fire, last;
  logic          unused_bits;

  assign idx      = reg_addr[4:2];
  assign busy     = st != S_IDLE;
  assign sr_wr    = reg_we && idx == 3'd4 && reg_wdata[0];
  assign clr_wr   = reg_we && idx == 3'd4 && reg_wdata[1];
  assign len_wr   = reg_we && (idx == 3'd2 || idx == 3'd3);
  assign src_fire = st == S_FETCH && (to_cart ? mem_ready : cart_ready);
  assign dst_fire = st == S_STORE && (to_cart ? cart_ready : mem_ready);
  assign last     = cnt[LW-1:1] == '0;
  assign unused_bits = ^{reg_addr[1:0], reg_wdata[31:AW], reg_wdata[31:LW]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; to_cart <= 1'b0; err <= 1'b0; irq_q <= 1'b0;
      maddr <= '0; caddr <= '0; len_m2c <= '0; len_c2m <= '0;
      cnt <= '0; hbuf <= '0;
    end else if (sr_wr) begin
      st <= S_IDLE; err <= 1'b0; irq_q <= 1'b0;
    end else begin
      if (clr_wr) irq_q <= 1'b0;
      if (reg_we && !busy && idx == 3'd0) maddr <= {reg_wdata[AW-1:1], 1'b0};
      if (reg_we && !busy && idx == 3'd1) caddr <= {reg_wdata[AW-1:1], 1'b0};
      if (len_wr) begin
        if (busy) err <= 1'b1;
        else begin
          to_cart <= idx == 3'd2;
          st      <= S_FETCH;
          if (idx == 3'd2) begin
            len_m2c <= reg_wdata[LW-1:0] | LW'(1);
            cnt     <= reg_wdata[LW-1:0] | LW'(1);
          end else begin
            len_c2m <= reg_wdata[LW-1:0];
            cnt     <= reg_wdata[LW-1:0];
          end
        end
      end
      if (src_fire) begin
        hbuf <= to_cart ? mem_rdata : cart_rdata;
        st   <= S_STORE;
      end
      if (dst_fire) begin
        maddr <= maddr + AW'(2);
        caddr <= caddr + AW'(2);
        if (last) begin
          st    <= S_IDLE;
          irq_q <= 1'b1;
        end else begin
          cnt <= cnt - LW'(2);
          st  <= S_FETCH;
        end
      end
    end
  end

  assign mem_valid  = (st == S_FETCH && to_cart) || (st == S_STORE && !to_cart);
  assign cart_valid = (st == S_FETCH && !to_cart) || (st == S_STORE && to_cart);
  assign mem_we     = st == S_STORE;
  assign cart_we    = st == S_STORE;
  assign mem_addr   = maddr;
  assign cart_addr  = caddr;
  assign mem_wdata  = hbuf;
  assign cart_wdata = hbuf;
  assign mem_be     = (st == S_STORE && cnt == '0) ? 2'b01 : 2'b11;
  assign irq        = irq_q;

  always_comb begin
    case (idx)
      3'd0:    reg_rdata = 32'(maddr);
      3'd1:    reg_rdata = 32'(caddr);
      3'd2:    reg_rdata = 32'(len_m2c);
      3'd3:    reg_rdata = 32'(len_c2m);
      3'd4:    reg_rdata = {27'd0, maddr[2:0] == 3'd0, irq_q, err, cart_valid, busy};
      default: reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/pdma_ctrl_chk.sv
module pdma_ctrl_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [4:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    mem_be,
  input logic          cart_valid,
  input logic          cart_ready,
  input logic [AW-1:0] cart_addr,
  input logic          irq,
  input logic          busy,
  input logic          err
);
  logic sr, lw;
  assign sr = reg_we && reg_addr[4:2] == 3'd4 && reg_wdata[0];
  assign lw = reg_we && (reg_addr[4:2] == 3'd2 || reg_addr[4:2] == 3'd3);

  p_even_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid |-> !mem_addr[0]) and (cart_valid |-> !cart_addr[0]));
  p_be_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> mem_be == 2'b11 || mem_be == 2'b01);
  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid && cart_valid));
  p_done_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(sr) |-> irq);
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sr |=> !busy && !err && !irq && !mem_valid && !cart_valid);
  p_busy_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && lw && !sr |=> err && busy);
  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready && !sr |=> mem_valid && $stable(mem_addr));
  p_cart_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cart_valid && !cart_ready && !sr |=> cart_valid && $stable(cart_addr));
endmodule

bind pdma_ctrl pdma_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_pdma_ctrl.sv
module sim_pdma_ctrl;
  localparam int AW = 24;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [4:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_valid, mem_ready, mem_we, cart_valid, cart_ready, cart_we, irq;
  logic [AW-1:0] mem_addr, cart_addr;
  logic [15:0] mem_wdata, cart_wdata, mem_rdata, cart_rdata;
  logic [1:0] mem_be;

  pdma_ctrl #(.AW(AW), .LW(24)) u0 (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  logic init_req = 0, stall = 0, hold_mem = 0, hold_cart = 0;
  logic [7:0] lfsr = 8'h5B;
  logic [15:0] mem_arr [64];
  logic [15:0] cart_arr [64];
  logic [15:0] exp_mem [64];
  logic [15:0] exp_cart [64];

  function automatic logic [15:0] mem_pat(int i);
    return 16'(i * 257 + 16'h3C11);
  endfunction
  function automatic logic [15:0] cart_pat(int i);
    return 16'(i * 4099 + 16'h0081);
  endfunction

  always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  assign mem_ready  = hold_mem  ? 1'b0 : (stall ? lfsr[0] : 1'b1);
  assign cart_ready = hold_cart ? 1'b0 : (stall ? lfsr[3] : 1'b1);
  assign mem_rdata  = mem_arr[mem_addr[6:1]];
  assign cart_rdata = cart_arr[cart_addr[6:1]];

  always @(posedge clk) begin
    if (init_req) begin
      for (int i = 0; i < 64; i++) begin
        mem_arr[i]  <= mem_pat(i);
        cart_arr[i] <= cart_pat(i);
      end
    end else begin
      if (mem_valid && mem_ready && mem_we) begin
        if (mem_be[0]) mem_arr[mem_addr[6:1]][7:0]  <= mem_wdata[7:0];
        if (mem_be[1]) mem_arr[mem_addr[6:1]][15:8] <= mem_wdata[15:8];
      end
      if (cart_valid && cart_ready && cart_we) cart_arr[cart_addr[6:1]] <= cart_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic reinit();
    @(negedge clk); init_req = 1;
    @(negedge clk); init_req = 0;
    for (int i = 0; i < 64; i++) begin exp_mem[i] = mem_pat(i); exp_cart[i] = cart_pat(i); end
  endtask

  task automatic model(input bit to_cart, input int ma, input int ca, input int n);
    for (int k = 0; k < n; k++) begin
      int sb, db;
      logic [7:0] b;
      sb = to_cart ? ma + k : ca + k;
      db = to_cart ? ca + k : ma + k;
      b = to_cart ? exp_mem[sb >> 1][(sb & 1) * 8 +: 8] : exp_cart[sb >> 1][(sb & 1) * 8 +: 8];
      if (to_cart) exp_cart[db >> 1][(db & 1) * 8 +: 8] = b;
      else         exp_mem[db >> 1][(db & 1) * 8 +: 8] = b;
    end
  endtask

  task automatic compare(input string tag);
    int mis = 0, first = -1;
    for (int i = 0; i < 64; i++)
      if (mem_arr[i] !== exp_mem[i] || cart_arr[i] !== exp_cart[i]) begin
        mis++; if (first < 0) first = i;
      end
    chk(mis == 0, tag, mis, 0);
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] s;
    bit early = 0, done = 0;
    for (int k = 0; k < 4000; k++) begin
      rd(5'h10, s);
      if (!s[0]) begin done = 1; break; end
      if (s[3]) early = 1;
      @(negedge clk);
    end
    chk(done && !early && s[3] && irq, {tag, " R6 busy drop with completion"}, {early, s[3:0], irq}, 5'b01000 | 1);
  endtask

  task automatic xfer(input bit to_cart, input int ma, input int ca, input int lenv, input bit st_i);
    logic [31:0] d;
    int n, hw;
    stall = st_i;
    reinit();
    wr(5'h00, ma); wr(5'h04, ca);
    wr(to_cart ? 5'h08 : 5'h0C, lenv);
    n  = to_cart ? ((lenv | 1) + 1) : lenv + 1;
    hw = (n + 1) / 2;
    model(to_cart, ma, ca, n);
    wait_done(to_cart ? "R2" : "R3");
    compare(to_cart ? "R2 R4 copy to cartridge" : "R3 R4 copy to memory");
    rd(5'h00, d); chk(d == ma + 2 * hw, "R4 memory address after", d, ma + 2 * hw);
    rd(5'h04, d); chk(d == ca + 2 * hw, "R4 cartridge address after", d, ca + 2 * hw);
    rd(to_cart ? 5'h08 : 5'h0C, d);
    chk(d == (to_cart ? (lenv | 1) : lenv), to_cart ? "R2 length readback" : "R3 length readback",
        d, to_cart ? (lenv | 1) : lenv);
    wr(5'h10, 32'h2);
    rd(5'h10, d); chk(!irq && !d[3], "R7 completion clear", {irq, d[3]}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, a0, a1, keep;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    for (int r = 0; r < 4; r++) begin
      rd(5'(r * 4), d); chk(d == 0, "R12 register reset", d, 0);
    end
    rd(5'h10, d); chk(d == 32'h10, "R12 status reset", d, 32'h10);
    chk(!mem_valid && !cart_valid && !irq, "R12 ports idle", {mem_valid, cart_valid, irq}, 0);

    // R1 odd address forced even, R5 alignment flag
    wr(5'h00, 32'h0000_0019); rd(5'h00, d); chk(d == 32'h18, "R1 memory address bit0", d, 32'h18);
    wr(5'h04, 32'h0000_0033); rd(5'h04, d); chk(d == 32'h32, "R1 cartridge address bit0", d, 32'h32);
    rd(5'h10, d); chk(d[4] == 1, "R5 aligned flag set", d[4], 1);
    wr(5'h00, 32'h0000_000A); rd(5'h10, d); chk(d[4] == 0, "R5 aligned flag clear", d[4], 0);

    // sweep both directions, lengths, offsets, ready patterns
    for (int dir = 0; dir < 2; dir++)
      for (int l = 0; l < 10; l++)
        for (int m = 0; m < 3; m++)
          for (int c = 0; c < 2; c++)
            xfer(dir[0], (m == 0) ? 0 : (m == 1) ? 8 : 22, c ? 40 : 4, l, l[0] ^ c[0]);

    // R5 IO busy, R10 hold, R11 address writes ignored while busy
    stall = 0; reinit();
    wr(5'h00, 32'h10); wr(5'h04, 32'h20);
    hold_cart = 1;
    wr(5'h0C, 32'd6);
    rd(5'h10, d); chk(d[1:0] == 2'b11, "R5 busy and cartridge request", d[1:0], 3);
    a0 = cart_addr;
    wr(5'h04, 32'h30); wr(5'h00, 32'h30);
    repeat (3) @(negedge clk);
    chk(cart_valid && cart_addr == a0, "R10 request held", {cart_valid, cart_addr}, {1'b1, a0});
    hold_cart = 0;
    model(0, 32'h10, 32'h20, 7);
    wait_done("R11");
    compare("R11 copy unaffected by address writes");
    rd(5'h04, d); chk(d == 32'h28, "R11 cartridge address", d, 32'h28);
    rd(5'h00, d); chk(d == 32'h18, "R11 memory address", d, 32'h18);
    wr(5'h10, 32'h2);

    // R9 length write while busy
    stall = 1; reinit();
    rd(5'h0C, keep);
    wr(5'h00, 32'h0); wr(5'h04, 32'h4);
    wr(5'h08, 32'd19);
    wr(5'h0C, 32'd3);
    rd(5'h10, d); chk(d[2] && d[0], "R9 error set, still busy", d[2:0], 5);
    model(1, 0, 4, 20);
    wait_done("R9");
    compare("R9 copy unaltered");
    rd(5'h0C, d); chk(d == keep, "R9 stored length unchanged", d, keep);
    rd(5'h10, d); chk(d[2] == 1, "R9 error sticky", d[2], 1);

    // R8 abort
    stall = 1; reinit();
    wr(5'h00, 32'h0); wr(5'h04, 32'h0);
    wr(5'h0C, 32'd39);
    repeat (9) @(negedge clk);
    wr(5'h10, 32'h1);
    rd(5'h10, d); chk(d[3:0] == 0 && !irq, "R8 status cleared by abort", d[3:0], 0);
    rd(5'h00, a0); rd(5'h04, a1);
    chk(a0 <= 40 && a0 == a1 && !a0[0], "R8 addresses consistent", a0, a1);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(!mem_valid && !cart_valid, "R8 no request after abort", {mem_valid, cart_valid}, 0);
    end
    rd(5'h00, d); chk(d == a0, "R8 memory address kept", d, a0);
    rd(5'h04, d); chk(d == a1, "R8 cartridge address kept", d, a1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule